// File: doc/BRIEF.md
# Pad Configuration Register File with Keyed Commit Guard

This block stores the per-pin pad configuration for a bank of eight pins and exposes it on a simple single-cycle register bus. Most of these registers are plain 8-bit storage: three drive-strength selects, open-drain enable, slew control, digital enable and analog mode select. Each one drives its own pad-control output.

The alternate-function select is protected by two guards. A commit mask decides which of its bits software may change. The commit mask can only be rewritten while a lock is open. The lock opens only when the full 32-bit unlock key 0x0ACCE551 is written to the lock register. Any other value written there closes the lock again. Software that wants to move a protected pin to or from its alternate function must therefore open the lock, widen the commit mask, and only then write the select.

Top module: `padcfg_guard`

## Requirements
- R1: After reset the lock reads 1, the commit mask reads 0xFF, the alternate-function select reads 0, the 2 mA drive register reads 0xFF, and every other register reads 0.
- R2: A write of exactly 0x0ACCE551 to the lock register (offset 0x520) opens the lock, and the lock register then reads 0.
- R3: A write of any other 32-bit value to the lock register closes the lock, including a value that matches the key only in its low bits. The lock register then reads 1.
- R4: While the lock is closed, a write to the commit register (offset 0x524) leaves the commit mask unchanged.
- R5: While the lock is open, a write to the commit register stores write-data bits [7:0]. The lock stays open until the next write to the lock register.
- R6: A write to the alternate-function select (offset 0x420) changes only the bits whose commit-mask bit is 1. Every other bit keeps its value.
- R7: The plain registers store write-data bits [7:0] and ignore the upper bits. Their offsets are: 2 mA drive 0x500, 4 mA drive 0x504, 8 mA drive 0x508, open drain 0x50C, slew 0x518, digital enable 0x51C, analog select 0x528.
- R8: A read of an unmapped offset returns 0, and a write to one changes no register.
- R9: Each pad-control output equals the value of its register.
- R10: Read data is the register value zero-extended to 32 bits. It is valid in the same cycle as the address, and a write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte offset for the read or write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| alt_sel_o | output | 8 | Alternate-function select per pin |
| drv2_o | output | 8 | 2 mA drive select per pin |
| drv4_o | output | 8 | 4 mA drive select per pin |
| drv8_o | output | 8 | 8 mA drive select per pin |
| odrain_o | output | 8 | Open-drain enable per pin |
| slew_o | output | 8 | Slew-rate control per pin |
| den_o | output | 8 | Digital enable per pin |
| ana_o | output | 8 | Analog mode select per pin |

## Verification
The bench targets the following corner cases. A value equal to the key in its low 28 bits but not in bit 28 must close the lock. A design that compares only part of the word would open it instead. A commit write issued while the lock is closed must be dropped. A design that gates on the wrong lock polarity would overwrite the mask. An alternate-function write under a partial commit mask must keep the masked bits. A design that writes the whole byte would return the wrong merged value. The bench also confirms that the lock stays open across a commit write, that a write to an unmapped offset disturbs no neighbouring register, and that a mid-run reset restores the locked state and the 0xFF drive default.

// File: rtl/padcfg_pkg.sv
package padcfg_pkg;
    localparam int PINS   = 8;
    localparam int AW     = 12;
    localparam int DW     = 32;
    localparam int NPLAIN = 7;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h0ACC_E551;

    localparam logic [AW-1:0] OFF_ALT    = 12'h420;
    localparam logic [AW-1:0] OFF_LOCK   = 12'h520;
    localparam logic [AW-1:0] OFF_COMMIT = 12'h524;

    // plain register index: 0 drv2, 1 drv4, 2 drv8, 3 odrain, 4 slew, 5 den, 6 ana
    localparam logic [NPLAIN-1:0][AW-1:0] PLAIN_OFF = {
        12'h528, 12'h51C, 12'h518, 12'h50C, 12'h508, 12'h504, 12'h500
    };
    localparam logic [NPLAIN-1:0][PINS-1:0] PLAIN_RST = {
        8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'hFF
    };

    typedef struct packed {
        logic            locked;
        logic [PINS-1:0] commit;
        logic [PINS-1:0] alt;
    } guard_st_t;
endpackage

// File: rtl/padcfg_guard_core.sv
module padcfg_guard_core
    import padcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic            locked_o,
    output logic [PINS-1:0] commit_o,
    output logic [PINS-1:0] alt_o
);
    localparam guard_st_t RST_ST = '{locked: 1'b1, commit: '1, alt: '0};

    guard_st_t st_d, st_q;

    logic wr_lock, wr_commit, wr_alt;

    always_comb begin
        wr_lock   = wr && (addr == OFF_LOCK);
        wr_commit = wr && (addr == OFF_COMMIT);
        wr_alt    = wr && (addr == OFF_ALT);
        st_d = st_q;
        if (wr_lock) begin
            st_d.locked = (wdata != UNLOCK_KEY);
        end
        if (wr_commit && !st_q.locked) begin
            st_d.commit = wdata[PINS-1:0];
        end
        if (wr_alt) begin
            st_d.alt = (st_q.alt & ~st_q.commit) | (wdata[PINS-1:0] & st_q.commit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_ST;
        else        st_q <= st_d;
    end

    assign locked_o = st_q.locked;
    assign commit_o = st_q.commit;
    assign alt_o    = st_q.alt;

    p_key_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_LOCK && wdata == UNLOCK_KEY) |=> !locked_o);

    p_bad_key_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == OFF_LOCK && wdata != UNLOCK_KEY) |=> locked_o);

    p_commit_guarded_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !(wr && addr == OFF_LOCK)) |=> $stable(commit_o));

    p_lock_persists_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == OFF_LOCK) |=> $stable(locked_o));

    p_alt_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((alt_o ^ $past(alt_o)) & ~$past(commit_o)) == '0);
endmodule

// File: rtl/padcfg_plain.sv
module padcfg_plain
    import padcfg_pkg::*;
#(
    parameter logic [AW-1:0]   OFFSET = 12'h500,
    parameter logic [PINS-1:0] RSTVAL = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [PINS-1:0] val_o
);
    logic [PINS-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr && addr == OFFSET) val_d = wdata[PINS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RSTVAL;
        else        val_q <= val_d;
    end

    assign val_o = val_q;

    p_plain_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && addr == OFFSET) |=> $stable(val_o));
endmodule

// File: rtl/padcfg_guard.sv
module padcfg_guard
    import padcfg_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_wr,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    output logic [PINS-1:0] alt_sel_o,
    output logic [PINS-1:0] drv2_o,
    output logic [PINS-1:0] drv4_o,
    output logic [PINS-1:0] drv8_o,
    output logic [PINS-1:0] odrain_o,
    output logic [PINS-1:0] slew_o,
    output logic [PINS-1:0] den_o,
    output logic [PINS-1:0] ana_o
);
    logic                  locked;
    logic [PINS-1:0]       commit;
    logic [PINS-1:0]       alt;
    logic [PINS-1:0]       plain_val [NPLAIN];

    padcfg_guard_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .locked_o (locked),
        .commit_o (commit),
        .alt_o    (alt)
    );

    for (genvar g = 0; g < NPLAIN; g++) begin : g_plain
        padcfg_plain #(
            .OFFSET (PLAIN_OFF[g]),
            .RSTVAL (PLAIN_RST[g])
        ) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (bus_wr),
            .addr  (bus_addr),
            .wdata (bus_wdata),
            .val_o (plain_val[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFF_LOCK)   bus_rdata = DW'(locked);
        if (bus_addr == OFF_COMMIT) bus_rdata = DW'(commit);
        if (bus_addr == OFF_ALT)    bus_rdata = DW'(alt);
        for (int i = 0; i < NPLAIN; i++) begin
            if (bus_addr == PLAIN_OFF[i]) bus_rdata = DW'(plain_val[i]);
        end
    end

    assign alt_sel_o = alt;
    assign drv2_o    = plain_val[0];
    assign drv4_o    = plain_val[1];
    assign drv8_o    = plain_val[2];
    assign odrain_o  = plain_val[3];
    assign slew_o    = plain_val[4];
    assign den_o     = plain_val[5];
    assign ana_o     = plain_val[6];
endmodule

// File: tb/padcfg_guard_bench.sv
module padcfg_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  alt_sel_o, drv2_o, drv4_o, drv8_o, odrain_o, slew_o, den_o, ana_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;   // 50 MHz

    padcfg_guard u_padcfg_guard (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alt_sel_o(alt_sel_o),
        .drv2_o(drv2_o), .drv4_o(drv4_o), .drv8_o(drv8_o), .odrain_o(odrain_o),
        .slew_o(slew_o), .den_o(den_o), .ana_o(ana_o)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] waddr;
        logic [31:0] wdata;
        logic [11:0] raddr;
        logic [7:0]  exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h420, 32'h0000_00FF, 12'h420, 8'hFF, 8'd6}, // R6 full mask
        '{1'b1, 12'h524, 32'h0000_000F, 12'h524, 8'hFF, 8'd4}, // R4 locked
        '{1'b1, 12'h520, 32'h0ACC_E551, 12'h520, 8'h00, 8'd2}, // R2 key
        '{1'b1, 12'h524, 32'h0000_000F, 12'h524, 8'h0F, 8'd5}, // R5 commit
        '{1'b0, 12'h000, 32'h0000_0000, 12'h520, 8'h00, 8'd5}, // R5 still open
        '{1'b1, 12'h420, 32'h0000_0000, 12'h420, 8'hF0, 8'd6}, // R6 partial
        '{1'b1, 12'h420, 32'h0000_00AA, 12'h420, 8'hFA, 8'd6}, // R6 partial
        '{1'b1, 12'h520, 32'h1ACC_E551, 12'h520, 8'h01, 8'd3}, // R3 near key
        '{1'b1, 12'h524, 32'h0000_0000, 12'h524, 8'h0F, 8'd4}, // R4 locked
        '{1'b1, 12'h520, 32'h0ACC_E551, 12'h520, 8'h00, 8'd2}, // R2 reopen
        '{1'b1, 12'h524, 32'h0000_03C3, 12'h524, 8'hC3, 8'd5}, // R5 low byte
        '{1'b1, 12'h520, 32'h0000_0000, 12'h520, 8'h01, 8'd3}, // R3 zero
        '{1'b1, 12'h508, 32'h0001_2345, 12'h508, 8'h45, 8'd7}, // R7 drv8
        '{1'b1, 12'h50C, 32'h0000_005A, 12'h50C, 8'h5A, 8'd7}, // R7 odrain
        '{1'b1, 12'h518, 32'h0000_0033, 12'h518, 8'h33, 8'd7}, // R7 slew
        '{1'b1, 12'h51C, 32'h0000_0081, 12'h51C, 8'h81, 8'd7}, // R7 den
        '{1'b1, 12'h528, 32'h0000_007E, 12'h528, 8'h7E, 8'd7}, // R7 ana
        '{1'b1, 12'h500, 32'h0000_0000, 12'h500, 8'h00, 8'd7}, // R7 drv2
        '{1'b1, 12'h504, 32'h0000_00C3, 12'h504, 8'hC3, 8'd7}, // R7 drv4
        '{1'b1, 12'h52C, 32'hFFFF_FFFF, 12'h52C, 8'h00, 8'd8}  // R8 unmapped
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [11:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic reset_checks();
        read_check("R1 lock",   12'h520, 32'h1);
        read_check("R1 commit", 12'h524, 32'hFF);
        read_check("R1 alt",    12'h420, 32'h0);
        read_check("R1 drv2",   12'h500, 32'hFF);
        read_check("R1 drv4",   12'h504, 32'h0);
        read_check("R1 ana",    12'h528, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].wr) bus_write(VECS[i].waddr, VECS[i].wdata);
            read_check($sformatf("R%0d step %0d", VECS[i].req, i), VECS[i].raddr, 32'(VECS[i].exp));
        end

        // R8: unmapped write left neighbours alone
        read_check("R8 ana kept", 12'h528, 32'h7E);
        read_check("R8 lock kept", 12'h520, 32'h1);
        // R9: outputs mirror registers
        check("R9 alt",    32'(alt_sel_o), 32'hFA);
        check("R9 drv2",   32'(drv2_o),    32'h00);
        check("R9 drv4",   32'(drv4_o),    32'hC3);
        check("R9 drv8",   32'(drv8_o),    32'h45);
        check("R9 odrain", 32'(odrain_o),  32'h5A);
        check("R9 slew",   32'(slew_o),    32'h33);
        check("R9 den",    32'(den_o),     32'h81);
        check("R9 ana",    32'(ana_o),     32'h7E);
        // R10: upper read bits zero on a plain register
        read_check("R10 zero-extend", 12'h504, 32'h0000_00C3);

        // R1: mid-run reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        reset_checks();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule